// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block controls one port of general-purpose pins, eight by default. For each pin, software chooses through registers whether the pin is digital or analog. For a digital pin it also chooses whether the output is push-pull or open-drain, and it sets the output level in a latch register. From these bits the block drives three control lines to each pad: an enable for the high-side driver, an enable for the low-side driver and an enable for the weak pullup. The pad's sensed level comes back in, passes through a two-stage synchronizer and can be read at a fourth address.

Analog pins are fully quiet on the digital side. No driver and no pullup is enabled, and the input always reads back as zero. When a digital pin is not actively pulled low, its pullup is on. A pin that is driven low never has its pullup on. Reset and a synchronous wake-up input both return every pin to digital, open-drain, latch high. That is the high-impedance, pulled-up state.

Register map (`wrAddr`/`rdAddr`): 0 is the output latch, 1 is the digital-mode bits (1 = digital, 0 = analog), 2 is the output-type bits (1 = push-pull, 0 = open-drain) and 3 is the input value, which is read-only. Bit i of each register belongs to pin i.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, latch reads 0xFF, digital-mode reads 0xFF and output-type reads 0x00. padDriveHi is 0x00, padDriveLo is 0x00 and padPullup is 0xFF.
- R2: A write with wrEn high to address 0, 1 or 2 updates that register at the next rising clock edge, and the new value reads back at the same address.
- R3: A pin whose digital-mode bit is 0 has padDriveHi, padDriveLo and padPullup all 0, whatever its latch and output-type bits hold.
- R4: At address 3, bit i reads 0 while pin i is in analog mode, whatever level is on the pad.
- R5: A digital push-pull pin (type bit 1) has padDriveHi equal to its latch bit and padDriveLo equal to the inverse of its latch bit.
- R6: A digital open-drain pin (type bit 0) never has padDriveHi set, and has padDriveLo set exactly when its latch bit is 0.
- R7: A digital pin has padPullup set exactly when it is not driving low (latch bit 1). padPullup and padDriveLo are never both set on a pin.
- R8: For a digital pin, a change on padIn shows at address 3 after exactly two rising clock edges, and not after one.
- R9: wakeUp high at a rising edge restores the R1 register values, taking priority over a write in the same cycle.
- R10: A write to address 3 changes no register and no pad-control output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wakeUp | input | 1 | Synchronous return to default state |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address |
| wrData | input | 8 | Write data |
| rdAddr | input | 2 | Read address |
| rdData | output | 8 | Read data (combinational) |
| padIn | input | 8 | Sensed pad levels |
| padDriveHi | output | 8 | High-side driver enables |
| padDriveLo | output | 8 | Low-side driver enables |
| padPullup | output | 8 | Weak pullup enables |

## Verification
The hardest situation to reach is a wake-up that lands in the same cycle as a register write. The bench first moves the latch away from its default, then raises wakeUp and a latch write together on one negative edge, so that priority alone decides the result. The analog input mask is also hard to see, because a floating analog pad already reads low. To make it visible, the bench's pad model drives a high level onto pins that are in analog mode. The synchronizer depth is checked by sampling on both sides of the second edge after an external driver pulls a pin low.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_LATCH = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_MODE  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_TYPE  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_INPUT = 2'd3;

  typedef struct packed {
    logic wrLatch;
    logic wrMode;
    logic wrType;
    logic wake;
  } ctlStrobe_t;
endpackage

// File: rtl/gpio_port_ctrl_regif.sv
module gpio_port_ctrl_regif
  import gpio_port_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wakeUp,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output ctlStrobe_t        stb
);
  always_comb begin
    stb.wake    = wakeUp;
    stb.wrLatch = wrEn && (wrAddr == ADDR_LATCH);
    stb.wrMode  = wrEn && (wrAddr == ADDR_MODE);
    stb.wrType  = wrEn && (wrAddr == ADDR_TYPE);
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrLatch, stb.wrMode, stb.wrType})) else $error("strobes overlap"); // R2
  AST_INPUT_RO: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_INPUT) |-> !(stb.wrLatch || stb.wrMode || stb.wrType)) else $error("input addr wrote"); // R10
endmodule

// File: rtl/gpio_port_ctrl_datapath.sv
module gpio_port_ctrl_datapath
  import gpio_port_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        stb,
  input  logic [PINS-1:0]   wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [PINS-1:0]   rdData,
  input  logic [PINS-1:0]   padIn,
  output logic [PINS-1:0]   padDriveHi,
  output logic [PINS-1:0]   padDriveLo,
  output logic [PINS-1:0]   padPullup
);
  localparam logic [PINS-1:0] LATCH_DEF = '1;
  localparam logic [PINS-1:0] MODE_DEF  = '1;
  localparam logic [PINS-1:0] TYPE_DEF  = '0;

  logic [PINS-1:0] latchReg, modeDig, typePP;
  logic [PINS-1:0] syncA, syncB, inView;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchReg <= LATCH_DEF;
      modeDig  <= MODE_DEF;
      typePP   <= TYPE_DEF;
    end else if (stb.wake) begin
      latchReg <= LATCH_DEF;
      modeDig  <= MODE_DEF;
      typePP   <= TYPE_DEF;
    end else begin
      if (stb.wrLatch) latchReg <= wrData;
      if (stb.wrMode)  modeDig  <= wrData;
      if (stb.wrType)  typePP   <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
    end
  end

  for (genvar i = 0; i < PINS; i++) begin : gPin
    always_comb begin
      padDriveHi[i] = modeDig[i] && typePP[i] && latchReg[i];
      padDriveLo[i] = modeDig[i] && !latchReg[i];
      padPullup[i]  = modeDig[i] && latchReg[i];
      inView[i]     = modeDig[i] && syncB[i];
    end
  end

  always_comb begin
    case (rdAddr)
      ADDR_LATCH: rdData = latchReg;
      ADDR_MODE:  rdData = modeDig;
      ADDR_TYPE:  rdData = typePP;
      default:    rdData = inView;
    endcase
  end

  logic [1:0] syncAge;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncAge <= '0;
    else if (syncAge != 2'd2) syncAge <= syncAge + 2'd1;
  end

  AST_WAKE_DEFAULTS: assert property (@(posedge clk) disable iff (!rstN)
    stb.wake |=> (latchReg == LATCH_DEF && modeDig == MODE_DEF && typePP == TYPE_DEF)) else $error("wake"); // R9
  AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrLatch && !stb.wake) |=> latchReg == $past(wrData)) else $error("latch write"); // R2
  AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (padDriveHi & ~typePP) == '0) else $error("od high"); // R6
  AST_PULL_OFF_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (padPullup & padDriveLo) == '0) else $error("pullup while low"); // R7
  AST_ANALOG_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ((padDriveHi | padDriveLo | padPullup) & ~modeDig) == '0) else $error("analog active"); // R3
  AST_ANALOG_READ: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == ADDR_INPUT) |-> (rdData & ~modeDig) == '0) else $error("analog read"); // R4
  AST_SYNC_LAG: assert property (@(posedge clk) disable iff (!rstN)
    (syncAge == 2'd2) |-> syncB == $past(padIn, 2)) else $error("sync lag"); // R8
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wakeUp,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [PINS-1:0]   wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [PINS-1:0]   rdData,
  input  logic [PINS-1:0]   padIn,
  output logic [PINS-1:0]   padDriveHi,
  output logic [PINS-1:0]   padDriveLo,
  output logic [PINS-1:0]   padPullup
);
  ctlStrobe_t stb;

  gpio_port_ctrl_regif uRegif (
    .clk(clk), .rstN(rstN), .wakeUp(wakeUp), .wrEn(wrEn), .wrAddr(wrAddr), .stb(stb)
  );

  gpio_port_ctrl_datapath #(.PINS(PINS)) uDatapath (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .padIn(padIn), .padDriveHi(padDriveHi), .padDriveLo(padDriveLo), .padPullup(padPullup)
  );
endmodule

// File: tb/gpio_port_ctrl_test.sv
module gpio_port_ctrl_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wakeUp = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [1:0] rdAddr = '0;
  logic [7:0] rdData, padIn, padDriveHi, padDriveLo, padPullup;
  logic [7:0] extEn = '0;
  logic [7:0] extVal = '0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_port_ctrl uut (
    .clk(clk), .rstN(rstN), .wakeUp(wakeUp), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .padIn(padIn), .padDriveHi(padDriveHi),
    .padDriveLo(padDriveLo), .padPullup(padPullup)
  );

  // resolved pad: own drivers first, then external driver, then pullup, else floats low
  always_comb begin
    for (int i = 0; i < 8; i++) begin
      if (padDriveHi[i])      padIn[i] = 1'b1;
      else if (padDriveLo[i]) padIn[i] = 1'b0;
      else if (extEn[i])      padIn[i] = extVal[i];
      else if (padPullup[i])  padIn[i] = 1'b1;
      else                    padIn[i] = 1'b0;
    end
  end

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] d);
    rdAddr = a;
    #1 d = rdData;
  endtask

  task automatic chkPads(input string req, input logic [7:0] hi, input logic [7:0] lo, input logic [7:0] pu);
    chk(req, "driveHi", padDriveHi, hi);
    chk(req, "driveLo", padDriveLo, lo);
    chk(req, "pullup", padPullup, pu);
  endtask

  task automatic chkRegs(input string req, input logic [7:0] l, input logic [7:0] m, input logic [7:0] t);
    logic [7:0] v;
    rdReg(2'd0, v); chk(req, "latch", v, l);
    rdReg(2'd1, v); chk(req, "mode", v, m);
    rdReg(2'd2, v); chk(req, "type", v, t);
  endtask

  task automatic tReset;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chkRegs("R1", 8'hFF, 8'hFF, 8'h00);
    chkPads("R1", 8'h00, 8'h00, 8'hFF);
  endtask

  task automatic tPushPull;
    wrReg(2'd2, 8'hFF);
    wrReg(2'd0, 8'hA5);
    chkRegs("R2", 8'hA5, 8'hFF, 8'hFF);
    chkPads("R5", 8'hA5, 8'h5A, 8'hA5);
  endtask

  task automatic tOpenDrain;
    wrReg(2'd2, 8'h00);
    chkPads("R6", 8'h00, 8'h5A, 8'hA5);
    wrReg(2'd2, 8'h0F);
    wrReg(2'd0, 8'h33);
    chkPads("R7", 8'h03, 8'hCC, 8'h33);
  endtask

  task automatic tAnalog;
    logic [7:0] v;
    wrReg(2'd1, 8'hF0);
    chkPads("R3", 8'h00, 8'hC0, 8'h30);
    @(negedge clk);
    extEn = 8'h0F; extVal = 8'h0F;
    repeat (3) @(negedge clk);
    rdReg(2'd3, v);
    chk("R4", "input", v, 8'h30);
  endtask

  task automatic tSync;
    logic [7:0] v;
    tReset();
    extEn = 8'h00;
    @(negedge clk);
    extEn = 8'h01; extVal = 8'h00;
    @(negedge clk);
    rdReg(2'd3, v); chk("R8", "after one edge", v, 8'hFF);
    @(negedge clk);
    rdReg(2'd3, v); chk("R8", "after two edges", v, 8'hFE);
    extEn = 8'h00;
  endtask

  task automatic tWake;
    wrReg(2'd0, 8'h0F);
    wrReg(2'd1, 8'h3C);
    @(negedge clk);
    wakeUp = 1'b1; wrEn = 1'b1; wrAddr = 2'd0; wrData = 8'h00;
    @(negedge clk);
    wakeUp = 1'b0; wrEn = 1'b0;
    chkRegs("R9", 8'hFF, 8'hFF, 8'h00);
    chkPads("R9", 8'h00, 8'h00, 8'hFF);
  endtask

  task automatic tInputRo;
    wrReg(2'd0, 8'h96);
    wrReg(2'd3, 8'h00);
    chkRegs("R10", 8'h96, 8'hFF, 8'h00);
    chkPads("R10", 8'h00, 8'h69, 8'h96);
  endtask

  initial begin
    tReset();
    tPushPull();
    tOpenDrain();
    tAnalog();
    tSync();
    tWake();
    tInputRo();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule